// File: doc/BRIEF.md
# Ramp-Compare ADC Sequencer

This block sequences a ramp-and-compare conversion across a group of channels. A single digital output charges an external RC network to produce a rising reference, then lets it discharge to produce a falling one. Each channel feeds back one comparator bit that tells whether its input lies above or below that reference. For each ramp, the block measures how many fast-clock periods pass from ramp start until the channel's comparator first changes. This gives a 9-bit raw time inside a 512-bin window.

The RC curve is exponential, so a raw time is not proportional to voltage. A loadable 512-entry table turns each time into a linear code. A rising ramp gives the table entry as it is, and a falling ramp gives its bitwise inverse, because the discharge curve mirrors the charge curve. Codes leave the block one channel at a time, each with a valid strobe, a channel index and a direction bit. While either ramp is running, a wait output stalls the attached host so that its bus activity adds no noise to the measurement.

A host loads the table through the write port and pulses start. Each conversion cycle then gives two samples per channel, rising first and falling second, and busy falls after the last one.

Top module: `ramp_adc_seq`

## Requirements
- R1: A start pulse while idle begins a rising ramp on the next cycle. rampOut is 1 for the 512 cycles of the rising ramp and its readout, and 0 for the falling ramp, its readout and idle.
- R2: waitOut is 1 during the 512 cycles of each ramp, so 1024 cycles per conversion cycle, and 0 during readout and idle.
- R3: In ramp cycle k (k = 0 at ramp start), the comparator value sampled at the end of cycle 0 is the baseline. The captured time is the first k in 1..511 at which the comparator differs from its value one cycle earlier. Any later changes in the same ramp are ignored.
- R4: If a channel's comparator does not change in cycles 1..511 of a ramp, that sample carries code all ones (4095 for 12 bits) and smpOvf = 1. Otherwise smpOvf = 0.
- R5: A rising-ramp sample (smpDir = 1) carries table[t]. A falling-ramp sample (smpDir = 0) carries the bitwise inverse of table[t], where t is the captured time.
- R6: When tblWe is 1 at a clock edge, table entry tblAddr takes tblData. Conversions after a reload use the new contents.
- R7: After each ramp, one sample per channel appears on consecutive cycles in channel order 0..N-1. The rising-ramp group comes first, then the falling-ramp group.
- R8: busy is 1 from the cycle after an accepted start through the cycle that carries the last falling-ramp sample, and 0 after it. A start pulse while busy is ignored.
- R9: After reset, rampOut, waitOut, busy and smpValid are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast clock; one period is one time bin |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a conversion cycle when idle |
| cmpIn | input | NUM_CH | Per-channel comparator results |
| tblWe | input | 1 | Table write enable |
| tblAddr | input | TBITS | Table write address |
| tblData | input | CODE_W | Table write data |
| rampOut | output | 1 | Drives the RC network (1 = charge) |
| waitOut | output | 1 | Host stall, high while a ramp runs |
| busy | output | 1 | Conversion cycle in progress |
| smpValid | output | 1 | Sample strobe |
| smpChan | output | $clog2(NUM_CH) | Channel index of the sample |
| smpDir | output | 1 | 1 = rising ramp, 0 = falling ramp |
| smpCode | output | CODE_W | Linearized code |
| smpOvf | output | 1 | No crossing in the window |

## Verification
The bench places crossings at the window edges, bin 1 and bin 511. A design off by one in its timer alignment would report the neighbouring table entry or flag a false overflow there. Comparators that cross back a few bins later catch a design that keeps the last transition instead of the first. Silent channels catch a design that reports a stale time instead of all ones. A table reload with identical crossings shows whether codes truly come through the table and whether the falling ramp inverts them. A start pulse injected mid-ramp would, in a faulty design, restart the sequence or add a second cycle of samples.

// File: rtl/ramp_adc_pkg.sv
package ramp_adc_pkg;

  // Strobes passed from the sequencer to the datapath.
  typedef struct packed {
    logic capArm;   // first cycle of a ramp: clear capture state
    logic capRun;   // ramp in progress: watch comparators
    logic rdEn;     // issue a table read for rdCh
    logic rdDir;    // direction tag of the read (1 = rising)
  } seq_ctl_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RISE,
    ST_READ_RISE,
    ST_FALL,
    ST_READ_FALL
  } seq_state_t;

endpackage

// File: rtl/ramp_adc_ctrl.sv
module ramp_adc_ctrl
  import ramp_adc_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int TBITS  = 9
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      start,
  output seq_ctl_t                  ctl,
  output logic [TBITS-1:0]          tbin,
  output logic [$clog2(NUM_CH)-1:0] rdCh,
  output logic                      rampOut,
  output logic                      waitOut,
  output logic                      busy
);

  localparam int CH_W  = $clog2(NUM_CH);
  localparam int CNT_W = $clog2(NUM_CH + 1);
  localparam logic [TBITS-1:0] TLAST = {TBITS{1'b1}};
  localparam logic [CNT_W-1:0] RLAST = CNT_W'(NUM_CH);

  seq_state_t        state;
  logic [TBITS-1:0]  timerQ;
  logic [CNT_W-1:0]  rdCntQ;
  logic              inRamp;
  logic              inRead;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      timerQ <= '0;
      rdCntQ <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          timerQ <= '0;
          rdCntQ <= '0;
          if (start) state <= ST_RISE;
        end
        ST_RISE, ST_FALL: begin
          if (timerQ == TLAST) begin
            timerQ <= '0;
            state  <= (state == ST_RISE) ? ST_READ_RISE : ST_READ_FALL;
          end else begin
            timerQ <= timerQ + 1'b1;
          end
        end
        ST_READ_RISE, ST_READ_FALL: begin
          if (rdCntQ == RLAST) begin
            rdCntQ <= '0;
            state  <= (state == ST_READ_RISE) ? ST_FALL : ST_IDLE;
          end else begin
            rdCntQ <= rdCntQ + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    inRamp     = (state == ST_RISE) || (state == ST_FALL);
    inRead     = (state == ST_READ_RISE) || (state == ST_READ_FALL);
    ctl.capRun = inRamp;
    ctl.capArm = inRamp && (timerQ == '0);
    ctl.rdEn   = inRead && (rdCntQ != RLAST);
    ctl.rdDir  = (state == ST_READ_RISE);
    tbin       = timerQ;
    rdCh       = rdCntQ[CH_W-1:0];
    rampOut    = (state == ST_RISE) || (state == ST_READ_RISE);
    waitOut    = inRamp;
    busy       = (state != ST_IDLE);
  end

endmodule

// File: rtl/ramp_adc_dp.sv
module ramp_adc_dp
  import ramp_adc_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int TBITS  = 9,
  parameter int CODE_W = 12
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  seq_ctl_t                  ctl,
  input  logic [TBITS-1:0]          tbin,
  input  logic [$clog2(NUM_CH)-1:0] rdCh,
  input  logic [NUM_CH-1:0]         cmpIn,
  input  logic                      tblWe,
  input  logic [TBITS-1:0]          tblAddr,
  input  logic [CODE_W-1:0]         tblData,
  output logic                      smpValid,
  output logic [$clog2(NUM_CH)-1:0] smpChan,
  output logic                      smpDir,
  output logic [CODE_W-1:0]         smpCode,
  output logic                      smpOvf
);

  localparam int CH_W  = $clog2(NUM_CH);
  localparam int DEPTH = 2 ** TBITS;

  logic             prevQ [NUM_CH];
  logic             hitQ  [NUM_CH];
  logic [TBITS-1:0] tcapQ [NUM_CH];

  // Per-channel first-transition capture.
  for (genvar g = 0; g < NUM_CH; g++) begin : g_cap
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        prevQ[g] <= 1'b0;
        hitQ[g]  <= 1'b0;
        tcapQ[g] <= '0;
      end else begin
        prevQ[g] <= cmpIn[g];
        if (ctl.capArm) begin
          hitQ[g] <= 1'b0;
        end else if (ctl.capRun && !hitQ[g] && (cmpIn[g] != prevQ[g])) begin
          hitQ[g]  <= 1'b1;
          tcapQ[g] <= tbin;
        end
      end
    end
  end

  // Linearization table: written by the host, read once per sample.
  logic [CODE_W-1:0] lut [DEPTH];

  always_ff @(posedge clk) begin
    if (tblWe) lut[tblAddr] <= tblData;
  end

  logic              vldQ;
  logic [CH_W-1:0]   chQ;
  logic              dirQ;
  logic              ovfQ;
  logic [CODE_W-1:0] rdDataQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vldQ    <= 1'b0;
      chQ     <= '0;
      dirQ    <= 1'b0;
      ovfQ    <= 1'b0;
      rdDataQ <= '0;
    end else begin
      vldQ <= ctl.rdEn;
      if (ctl.rdEn) begin
        chQ     <= rdCh;
        dirQ    <= ctl.rdDir;
        ovfQ    <= !hitQ[rdCh];
        rdDataQ <= lut[tcapQ[rdCh]];
      end
    end
  end

  always_comb begin
    smpValid = vldQ;
    smpChan  = chQ;
    smpDir   = dirQ;
    smpOvf   = ovfQ;
    if (ovfQ)      smpCode = '1;
    else if (dirQ) smpCode = rdDataQ;
    else           smpCode = ~rdDataQ;
  end

endmodule

// File: rtl/ramp_adc_seq.sv
module ramp_adc_seq
  import ramp_adc_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int TBITS  = 9,
  parameter int CODE_W = 12
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      start,
  input  logic [NUM_CH-1:0]         cmpIn,
  input  logic                      tblWe,
  input  logic [TBITS-1:0]          tblAddr,
  input  logic [CODE_W-1:0]         tblData,
  output logic                      rampOut,
  output logic                      waitOut,
  output logic                      busy,
  output logic                      smpValid,
  output logic [$clog2(NUM_CH)-1:0] smpChan,
  output logic                      smpDir,
  output logic [CODE_W-1:0]         smpCode,
  output logic                      smpOvf
);

  seq_ctl_t                  ctl;
  logic [TBITS-1:0]          tbin;
  logic [$clog2(NUM_CH)-1:0] rdCh;

  ramp_adc_ctrl #(.NUM_CH(NUM_CH), .TBITS(TBITS)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .ctl     (ctl),
    .tbin    (tbin),
    .rdCh    (rdCh),
    .rampOut (rampOut),
    .waitOut (waitOut),
    .busy    (busy)
  );

  ramp_adc_dp #(.NUM_CH(NUM_CH), .TBITS(TBITS), .CODE_W(CODE_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .tbin     (tbin),
    .rdCh     (rdCh),
    .cmpIn    (cmpIn),
    .tblWe    (tblWe),
    .tblAddr  (tblAddr),
    .tblData  (tblData),
    .smpValid (smpValid),
    .smpChan  (smpChan),
    .smpDir   (smpDir),
    .smpCode  (smpCode),
    .smpOvf   (smpOvf)
  );

endmodule

// File: rtl/ramp_adc_chk.sv
module ramp_adc_chk #(
  parameter int NUM_CH = 4,
  parameter int TBITS  = 9,
  parameter int CODE_W = 12
) (
  input logic                      clk,
  input logic                      rstN,
  input logic                      start,
  input logic [NUM_CH-1:0]         cmpIn,
  input logic                      tblWe,
  input logic [TBITS-1:0]          tblAddr,
  input logic [CODE_W-1:0]         tblData,
  input logic                      rampOut,
  input logic                      waitOut,
  input logic                      busy,
  input logic                      smpValid,
  input logic [$clog2(NUM_CH)-1:0] smpChan,
  input logic                      smpDir,
  input logic [CODE_W-1:0]         smpCode,
  input logic                      smpOvf
);

  // R1
  start_ramp_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && start) |=> (busy && waitOut && rampOut));

  // R2
  quiet_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    smpValid |-> !waitOut);

  // R8
  busy_cover_chk: assert property (@(posedge clk) disable iff (!rstN)
    (smpValid || waitOut) |-> busy);

  // R4
  ovf_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    (smpValid && smpOvf) |-> (smpCode == '1));

  // R7
  chan_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    (smpValid && $past(smpValid) && (smpChan != '0))
      |-> (smpChan == $past(smpChan) + 1'b1) && (smpDir == $past(smpDir)));

  // R8
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !smpValid) |=> busy);

endmodule

bind ramp_adc_seq ramp_adc_chk #(.NUM_CH(NUM_CH), .TBITS(TBITS), .CODE_W(CODE_W)) u_chk (.*);

// File: tb/sim_ramp_adc_seq.sv
`timescale 1ns/1ps
module sim_ramp_adc_seq;

  localparam int N     = 4;
  localparam int TB    = 9;
  localparam int CW    = 12;
  localparam int DEPTH = 512;
  localparam int MASK  = 4095;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          start = 1'b0;
  logic [N-1:0]  cmpIn = '0;
  logic          tblWe = 1'b0;
  logic [TB-1:0] tblAddr = '0;
  logic [CW-1:0] tblData = '0;
  logic          rampOut, waitOut, busy, smpValid, smpDir, smpOvf;
  logic [1:0]    smpChan;
  logic [CW-1:0] smpCode;

  always #10 clk = ~clk;

  ramp_adc_seq #(.NUM_CH(N), .TBITS(TB), .CODE_W(CW)) u0 (
    .clk(clk), .rstN(rstN), .start(start), .cmpIn(cmpIn),
    .tblWe(tblWe), .tblAddr(tblAddr), .tblData(tblData),
    .rampOut(rampOut), .waitOut(waitOut), .busy(busy),
    .smpValid(smpValid), .smpChan(smpChan), .smpDir(smpDir),
    .smpCode(smpCode), .smpOvf(smpOvf)
  );

  int nChk = 0;
  int nBad = 0;
  int tbl [DEPTH];
  int thrU [N], thrD [N], glU [N], glD [N];
  int gotCode [2][N];
  int gotOvf  [2][N];
  int nSamp, seqBad, waitCnt, rampBad, lastBusy;

  task automatic check(string req, string what, int act, int exp);
    nChk++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Sample monitor, away from the active edge.
  always @(negedge clk) begin
    if (waitOut) waitCnt++;
    if (smpValid) begin
      int d;
      d = smpDir ? 1 : 0;
      if ((int'(smpChan) != nSamp % N) || (d != ((nSamp < N) ? 1 : 0))) seqBad++;
      gotCode[d][smpChan] = int'(smpCode);
      gotOvf[d][smpChan]  = int'(smpOvf);
      if (nSamp == 2*N-1) lastBusy = int'(busy);
      nSamp++;
    end
  end

  function automatic int tblVal(int a, int salt);
    return (((a * a) >> 5) + a * 3 + salt) & MASK;
  endfunction

  function automatic logic cmpVal(int ch, int k, int thr, int gl);
    logic v;
    v = ch[0];
    if (thr >= 1 && k >= thr) v = ~v;
    if (gl > 0 && k >= gl) v = ~v;
    return v;
  endfunction

  function automatic int expCode(bit up, int thr);
    if (thr < 1 || thr > 511) return MASK;
    return up ? tbl[thr] : ((~tbl[thr]) & MASK);
  endfunction

  task automatic loadTable(int salt);
    for (int a = 0; a < DEPTH; a++) begin
      tblAddr = TB'(a);
      tblData = CW'(tblVal(a, salt));
      tblWe   = 1'b1;
      tbl[a]  = tblVal(a, salt);
      @(negedge clk);
    end
    tblWe = 1'b0;
    @(negedge clk);
  endtask

  task automatic rampPhase(bit up, bit midStart);
    for (int k = 0; k < DEPTH; k++) begin
      for (int ch = 0; ch < N; ch++)
        cmpIn[ch] = up ? cmpVal(ch, k, thrU[ch], glU[ch]) : cmpVal(ch, k, thrD[ch], glD[ch]);
      start = midStart && (k == 100);
      if (rampOut !== up || waitOut !== 1'b1 || busy !== 1'b1) rampBad++;
      @(negedge clk);
    end
    start = 1'b0;
  endtask

  task automatic convCycle(bit midStart);
    nSamp = 0; seqBad = 0; waitCnt = 0; rampBad = 0; lastBusy = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    rampPhase(1'b1, midStart);
    while (!waitOut) @(negedge clk);
    rampPhase(1'b0, 1'b0);
    while (busy) @(negedge clk);
  endtask

  task automatic checkSamples(string tag);
    for (int ch = 0; ch < N; ch++) begin
      check("R5", $sformatf("%s rising code ch%0d", tag, ch), gotCode[1][ch], expCode(1'b1, thrU[ch]));
      check("R5", $sformatf("%s falling code ch%0d", tag, ch), gotCode[0][ch], expCode(1'b0, thrD[ch]));
      check("R4", $sformatf("%s rising ovf ch%0d", tag, ch), gotOvf[1][ch], (thrU[ch] < 1 || thrU[ch] > 511) ? 1 : 0);
      check("R4", $sformatf("%s falling ovf ch%0d", tag, ch), gotOvf[0][ch], (thrD[ch] < 1 || thrD[ch] > 511) ? 1 : 0);
    end
    check("R7", {tag, " sample count"}, nSamp, 2*N);
    check("R7", {tag, " sample order"}, seqBad, 0);
    check("R2", {tag, " wait cycles"}, waitCnt, 2*DEPTH);
    check("R1", {tag, " ramp drive mismatches"}, rampBad, 0);
    check("R8", {tag, " busy at last sample"}, lastBusy, 1);
    check("R8", {tag, " busy after cycle"}, int'(busy), 0);
  endtask

  task automatic setThr(int u0, int u1, int u2, int u3, int d0, int d1, int d2, int d3);
    thrU[0] = u0; thrU[1] = u1; thrU[2] = u2; thrU[3] = u3;
    thrD[0] = d0; thrD[1] = d1; thrD[2] = d2; thrD[3] = d3;
    for (int ch = 0; ch < N; ch++) begin glU[ch] = 0; glD[ch] = 0; end
  endtask

  task automatic testReset();
    check("R9", "rampOut after reset", int'(rampOut), 0);
    check("R9", "waitOut after reset", int'(waitOut), 0);
    check("R9", "busy after reset", int'(busy), 0);
    check("R9", "smpValid after reset", int'(smpValid), 0);
  endtask

  // R3: window edges at bins 1 and 511
  task automatic testBasic();
    setThr(1, 77, 300, 511, 511, 200, 12, 1);
    convCycle(1'b0);
    checkSamples("R3 basic");
  endtask

  // R4: silent channels saturate
  task automatic testOverflow();
    setThr(40, 600, 250, 0, 90, 33, 9999, 480);
    convCycle(1'b0);
    checkSamples("R4 overflow");
  endtask

  // R3: later transitions in the same ramp are ignored
  task automatic testGlitch();
    setThr(50, 123, 7, 400, 60, 250, 301, 2);
    glU[0] = 51; glU[1] = 200; glU[2] = 8;  glU[3] = 450;
    glD[0] = 61; glD[1] = 252; glD[2] = 500; glD[3] = 3;
    convCycle(1'b0);
    checkSamples("R3 glitch");
  endtask

  // R6: reload changes codes for identical crossings
  task automatic testReload();
    loadTable(1234);
    setThr(1, 77, 300, 511, 511, 200, 12, 1);
    convCycle(1'b0);
    checkSamples("R6 reload");
  endtask

  // R8: start during a ramp is ignored
  task automatic testStartBusy();
    setThr(10, 20, 30, 40, 50, 60, 70, 80);
    convCycle(1'b1);
    checkSamples("R8 start busy");
    repeat (50) @(negedge clk);
    check("R8", "no extra cycle busy", int'(busy), 0);
    check("R8", "no extra samples", nSamp, 2*N);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nBad++;
    $display("FAIL R8 watchdog expired: actual busy %0d expected 0", busy);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    loadTable(0);
    testBasic();
    testOverflow();
    testGlitch();
    testReload();
    testStartBusy();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

endmodule